// File: doc/BRIEF.md
# Round-Robin Retry Issue Scheduler

This block is the issue stage of a multithreaded processor whose execution pipeline never stalls. Every hardware thread owns a one-entry instruction holding slot. A thread offers an instruction with its strobe, and the slot takes it whenever the thread's busy line is low. Each cycle a rotating selector picks one thread with a held instruction that is not blocked. That instruction goes to a single registered issue port, together with the thread's number.

A thread whose instruction cannot proceed raises its hold line. Its instruction stays parked in its slot and the selector passes over it, so the remaining threads keep issuing at full rate. Any number of threads may be parked at once. When a hold line drops, the parked instruction can be selected again in that same cycle, under the normal rotation. The rotation starts after the thread that issued last, so every thread that is able to issue gets a turn. No cycle is left empty while some thread is able to issue.

Top module: `rr_retry_issue`

## Requirements
- R1: After reset `iss_vld_o` is 0 and every bit of `thr_busy_o` is 0, because every slot is empty. The rotation pointer starts at thread 0.
- R2: The granted thread is the first thread that holds an instruction and is not blocked, searching upward from the pointer and wrapping from the highest index to 0. After each issue, the pointer moves to the index one above the issuing thread, wrapping to 0.
- R3: An instruction held in a slot is never lost or altered until it issues. It issues exactly once, with the same 32-bit value it was loaded with.
- R4: In any cycle where at least one thread holds an instruction and has `thr_hold_i` low, one instruction is issued. This holds even while other threads are parked, and a single thread alone may issue every cycle.
- R5: A thread with `thr_hold_i[t]` high is never granted. Once the hold drops, its parked instruction is eligible in that same cycle.
- R6: Several threads may hold parked instructions at the same time, and each keeps its own value.
- R7: `thr_busy_o[t]` is high exactly when slot t holds an instruction that is not being granted in the current cycle. While it is high, a strobe on that thread is ignored and the slot contents stay unchanged.
- R8: The issue port is registered. The clock edge that grants thread t drives `iss_vld_o`=1, `iss_instr_o` = the held instruction and `iss_tid_o` = t as a 2-bit binary number.
- R9: If no thread is eligible in a cycle, `iss_vld_o` is 0 after the following edge.
- R10: A strobe seen while `thr_busy_o[t]` is low loads `thr_instr_i[t]` into slot t at that edge. The instruction is eligible from the next cycle, and the busy line is high in that cycle if the instruction is not granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_vld_i | input | 4 | Per-thread strobe: an instruction is offered |
| thr_instr_i | input | 4x32 | Per-thread offered instruction |
| thr_hold_i | input | 4 | Per-thread block: the held instruction cannot proceed |
| thr_busy_o | output | 4 | Per-thread: slot occupied and not issuing now |
| iss_vld_o | output | 1 | An instruction is issued this cycle |
| iss_instr_o | output | 32 | Issued instruction |
| iss_tid_o | output | 2 | Thread number of the issued instruction |

## Verification
The directed phase first parks all four threads at once. It then offers replacement data while the slots are full, which tells an ignored strobe apart from an overwrite. Next it releases one thread alone and then all of them, which separates rejoin-in-the-same-cycle from a delayed rejoin and shows the rotation order after a wrap. A long pseudo-random sweep follows, covering every mix of strobes and hold lines. Each cycle is compared with a bench-side slot and pointer calculation, so a skipped thread, an idle cycle with an eligible thread, or a lost or duplicated instruction stands out at the port.

// File: rtl/rr_issue_pkg.sv
`timescale 1ns/1ps
package rr_issue_pkg;
    localparam int DEF_NTHR = 4;
    localparam int DEF_IW   = 32;
endpackage

// File: rtl/rr_thread_slot.sv
`timescale 1ns/1ps
// One-entry holding slot for a single thread.
module rr_thread_slot #(
    parameter int IW = rr_issue_pkg::DEF_IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_vld_i,
    input  logic [IW-1:0] load_instr_i,
    input  logic          grant_i,
    output logic          held_o,
    output logic [IW-1:0] instr_o,
    output logic          busy_o
);
    typedef struct packed {
        logic          vld;
        logic [IW-1:0] instr;
    } slot_st_t;

    slot_st_t st_d, st_q;

    // Occupied and not leaving this cycle: the slot cannot take a new one.
    assign busy_o  = st_q.vld & ~grant_i;
    assign held_o  = st_q.vld;
    assign instr_o = st_q.instr;

    always_comb begin
        st_d = st_q;
        if (grant_i) begin
            st_d.vld = 1'b0;
        end
        if (load_vld_i && !busy_o) begin
            st_d.vld   = 1'b1;
            st_d.instr = load_instr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HELD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !grant_i) |=> (held_o && $stable(instr_o))); // R3

    AST_GRANT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> held_o); // R3

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_vld_i && !busy_o) |=> (held_o && instr_o == $past(load_instr_i))); // R10
endmodule

// File: rtl/rr_rotor_pick.sv
`timescale 1ns/1ps
// Rotating first-eligible selector: searches upward from ptr_i with wrap.
module rr_rotor_pick #(
    parameter int N  = rr_issue_pkg::DEF_NTHR,
    parameter int TW = 2
) (
    input  logic [TW-1:0] ptr_i,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic          any_o,
    output logic [TW-1:0] idx_o
);
    always_comb begin
        int c;
        gnt_o = '0;
        any_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            c = int'(ptr_i) + k;
            if (c >= N) begin
                c = c - N;
            end
            if (!any_o && req_i[c]) begin
                any_o    = 1'b1;
                gnt_o[c] = 1'b1;
                idx_o    = TW'(c);
            end
        end
    end
endmodule

// File: rtl/rr_retry_issue.sv
`timescale 1ns/1ps
// Issue front end: per-thread holding slots, rotating selection, registered issue port.
module rr_retry_issue #(
    parameter  int NTHR = rr_issue_pkg::DEF_NTHR,
    parameter  int IW   = rr_issue_pkg::DEF_IW,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NTHR-1:0]           thr_vld_i,
    input  logic [NTHR-1:0][IW-1:0]   thr_instr_i,
    input  logic [NTHR-1:0]           thr_hold_i,
    output logic [NTHR-1:0]           thr_busy_o,
    output logic                      iss_vld_o,
    output logic [IW-1:0]             iss_instr_o,
    output logic [TIDW-1:0]           iss_tid_o
);
    typedef struct packed {
        logic            vld;
        logic [IW-1:0]   instr;
        logic [TIDW-1:0] tid;
        logic [TIDW-1:0] ptr;
    } iss_st_t;

    iss_st_t st_d, st_q;

    logic [NTHR-1:0]         held;
    logic [NTHR-1:0]         elig;
    logic [NTHR-1:0]         grant;
    logic [NTHR-1:0][IW-1:0] slot_instr;
    logic                    any_grant;
    logic [TIDW-1:0]         gidx;

    for (genvar t = 0; t < NTHR; t++) begin : g_slot
        rr_thread_slot #(.IW(IW)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_vld_i   (thr_vld_i[t]),
            .load_instr_i (thr_instr_i[t]),
            .grant_i      (grant[t]),
            .held_o       (held[t]),
            .instr_o      (slot_instr[t]),
            .busy_o       (thr_busy_o[t])
        );
    end

    assign elig = held & ~thr_hold_i;

    rr_rotor_pick #(.N(NTHR), .TW(TIDW)) u_pick (
        .ptr_i (st_q.ptr),
        .req_i (elig),
        .gnt_o (grant),
        .any_o (any_grant),
        .idx_o (gidx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = any_grant;
        st_d.instr = slot_instr[gidx];
        st_d.tid   = gidx;
        if (any_grant) begin
            st_d.ptr = (gidx == TIDW'(NTHR - 1)) ? '0 : gidx + TIDW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_vld_o   = st_q.vld;
    assign iss_instr_o = st_q.instr;
    assign iss_tid_o   = st_q.tid;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & thr_hold_i) == '0); // R5

    AST_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(held & ~thr_hold_i)) |-> (|grant)); // R4

    AST_ISSUE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> iss_vld_o); // R8

    AST_QUIET_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(held & ~thr_hold_i)) |=> !iss_vld_o); // R9

    AST_BUSY_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_busy_o & ~held) == '0); // R7
endmodule

// File: tb/rr_retry_issue_tb.sv
`timescale 1ns/1ps
module rr_retry_issue_tb;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       thr_vld_i = '0;
    logic [3:0][31:0] thr_instr_i = '0;
    logic [3:0]       thr_hold_i = '0;
    logic [3:0]       thr_busy_o;
    logic             iss_vld_o;
    logic [31:0]      iss_instr_o;
    logic [1:0]       iss_tid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench-side expectation state
    logic [3:0]       mv = '0;
    logic [3:0][31:0] md = '0;
    int               mptr = 0;
    logic             ev = 1'b0;
    logic [31:0]      ei = '0;
    int               et = 0;
    logic [31:0]      rng = 32'h1234_5679;

    rr_retry_issue u_dut (
        .clk, .rst_n, .thr_vld_i, .thr_instr_i, .thr_hold_i,
        .thr_busy_o, .iss_vld_o, .iss_instr_o, .iss_tid_o
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One cycle: drive, check busy, clock, update expectation, check issue port.
    task automatic step(input logic [3:0] v, input logic [3:0][31:0] d, input logic [3:0] h);
        int mg = -1;
        logic [3:0] mbusy;
        thr_vld_i   = v;
        thr_instr_i = d;
        thr_hold_i  = h;
        for (int k = 0; k < 4; k++) begin
            int c = (mptr + k) % 4;
            if (mg < 0 && mv[c] && !h[c]) mg = c;
        end
        mbusy = mv;
        if (mg >= 0) mbusy[mg] = 1'b0;
        #1;
        chk(thr_busy_o == mbusy, "R7 busy", 32'(thr_busy_o), 32'(mbusy));
        @(posedge clk);
        if (mg >= 0) begin
            ev = 1'b1; et = mg; ei = md[mg];
            mv[mg] = 1'b0;
            mptr = (mg + 1) % 4;
        end else begin
            ev = 1'b0;
        end
        for (int i = 0; i < 4; i++) begin
            if (v[i] && !mbusy[i]) begin
                mv[i] = 1'b1;
                md[i] = d[i];
            end
        end
        #1;
        chk(iss_vld_o == ev, ev ? "R4 issue strobe" : "R9 idle strobe", 32'(iss_vld_o), 32'(ev));
        if (ev) begin
            chk(iss_tid_o == 2'(et), "R2 thread order", 32'(iss_tid_o), 32'(et));
            chk(iss_instr_o == ei, "R3 instruction value", iss_instr_o, ei);
        end
    endtask

    initial begin
        logic [3:0][31:0] da, db;
        for (int i = 0; i < 4; i++) begin
            da[i] = 32'hA000_0000 + 32'(i);
            db[i] = 32'hBBBB_0000 + 32'(i);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(iss_vld_o == 1'b0, "R1 reset strobe", 32'(iss_vld_o), 0);
        chk(thr_busy_o == 4'h0, "R1 reset busy", 32'(thr_busy_o), 0);

        step(4'hF, da, 4'hF);                      // load all, all blocked
        chk(thr_busy_o == 4'hF, "R10 loaded slots busy", 32'(thr_busy_o), 32'hF);
        chk(iss_vld_o == 1'b0, "R9 all blocked", 32'(iss_vld_o), 0);
        step(4'hF, db, 4'hF);                      // strobes while busy are ignored
        chk(thr_busy_o == 4'hF, "R6 four parked", 32'(thr_busy_o), 32'hF);
        step(4'h0, db, 4'b1011);                   // release thread 2 only
        chk(iss_vld_o && iss_tid_o == 2'd2, "R5 rejoin tid", 32'(iss_tid_o), 2);
        chk(iss_instr_o == 32'hA000_0002, "R7 ignored strobe kept value", iss_instr_o, 32'hA000_0002);
        step(4'h0, db, 4'h0);
        chk(iss_tid_o == 2'd3, "R2 after 2 comes 3", 32'(iss_tid_o), 3);
        step(4'h0, db, 4'h0);
        chk(iss_tid_o == 2'd0, "R2 wrap to 0", 32'(iss_tid_o), 0);
        chk(iss_instr_o == 32'hA000_0000, "R8 issued value", iss_instr_o, 32'hA000_0000);
        step(4'h0, db, 4'h0);
        chk(iss_tid_o == 2'd1 && iss_instr_o == 32'hA000_0001, "R6 parked value kept",
            iss_instr_o, 32'hA000_0001);
        step(4'h0, db, 4'h0);
        chk(iss_vld_o == 1'b0, "R9 empty", 32'(iss_vld_o), 0);

        // single thread streaming: one issue per cycle once filled
        for (int n = 0; n < 8; n++) begin
            logic [3:0][31:0] ds = da;
            ds[0] = 32'hC000_0000 + 32'(n);
            step(4'h1, ds, 4'h0);
            if (n > 0) chk(iss_vld_o == 1'b1, "R4 single thread full rate", 32'(iss_vld_o), 1);
        end

        // pseudo-random sweep over strobe and hold mixes
        for (int n = 0; n < 4000; n++) begin
            logic [3:0][31:0] dr;
            logic [3:0] v, h;
            rng = nxt(rng);
            v = rng[3:0];
            h = rng[7:4] & rng[11:8];
            if (n % 50 < 10) h = rng[7:4] | rng[15:12];
            for (int i = 0; i < 4; i++) dr[i] = {2'(i), 14'(n), rng[31:16]};
            step(v, dr, h);
        end
        // drain everything
        for (int n = 0; n < 6; n++) step(4'h0, db, 4'h0);
        chk(thr_busy_o == 4'h0 && iss_vld_o == 1'b0, "R3 all drained", 32'(thr_busy_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule